// File: doc/BRIEF.md
# Reorder Buffer with Operand Capture and Result Broadcast

This block is the in-order retirement window of a small out-of-order core. Instructions enter at the tail of a circular buffer of slots. At entry, each of the two source operands is captured in one of two ways. It is read from the register file. If an older instruction still in the window writes that register, it is taken from that instruction instead. When the producer has not finished, the operand is left pending and the producer's slot index is kept as its tag.

An execution unit reports a result by slot tag. The result is stored in the producing slot and is sent in the same cycle to every pending operand that waits on that tag. Slots whose operands are all present are offered for issue, oldest first. Once accepted, a slot is never offered again. The head slot retires to the register file as soon as it holds its result. A flush empties the whole window.

Top module: `rob_core`

## Requirements
- R1: After reset, and on the clock edge that samples `flush_i` high, every slot becomes free and both pointers return to zero. `empty_o`=1, `full_o`=0, no issue request and no register-file write follow. During a flush cycle no insert, issue, writeback or commit takes effect, and `rf_we_o` is 0.
- R2: An insert is accepted when `ins_valid_i`=1 and `full_o`=0. It occupies slot `ins_tag_o`, the tail index. Tags run 0,1,2,… modulo DEPTH (8) from reset or flush, and advance by one per accepted insert.
- R3: `full_o` is 1 exactly when DEPTH slots are occupied, and `empty_o` is 1 exactly when none are. An insert offered while full is ignored: the occupancy, the tail tag and the slot contents stay as they were.
- R4: A source register with no older in-flight producer takes its value from `rf_rdata0_i` / `rf_rdata1_i`, which carry the register-file contents of `ins_src0_i` / `ins_src1_i` in the insert cycle.
- R5: When older in-flight slots write the source register, the youngest of them supplies the operand. If that slot already holds its result, the value is taken at once. Otherwise the operand stays pending on that slot's tag.
- R6: A writeback (`wb_valid_i`, `wb_tag_i`, `wb_data_i`) stores the data as the result of that slot and marks it done. In the same edge, it fills every pending operand in the window that waits on `wb_tag_i`.
- R7: If the youngest producer of a source register is written back in the same cycle as the insert, the inserted operand captures `wb_data_i` and is not left pending.
- R8: `issue_ready_o[i]` is 1 when slot i has not yet been issued, is not done, and has both operands present. `issue_valid_o` and `issue_tag_o` name the oldest such slot, counted from the head. `issue_op_o`, `issue_opnd0_o` and `issue_opnd1_o` give that slot's contents. With `issue_ack_i`=1 the slot is marked executing and never requests issue again.
- R9: When the head slot is done and no flush is present, `rf_we_o`=1 in that cycle. `rf_waddr_o` gives the slot's destination register and `rf_wdata_o` its result. The head then advances. Retirement is strictly in order: a done slot behind an unfinished head waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the window at the next edge |
| ins_valid_i | input | 1 | Insert request |
| ins_op_i | input | OP_W | Instruction payload |
| ins_dst_i | input | REG_W | Destination register |
| ins_src0_i | input | REG_W | First source register |
| ins_src1_i | input | REG_W | Second source register |
| rf_rdata0_i | input | DATA_W | Register-file contents of ins_src0_i |
| rf_rdata1_i | input | DATA_W | Register-file contents of ins_src1_i |
| ins_tag_o | output | TAG_W | Slot the next insert will take |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| wb_valid_i | input | 1 | Result writeback |
| wb_tag_i | input | TAG_W | Slot being written back |
| wb_data_i | input | DATA_W | Result value |
| issue_ready_o | output | DEPTH | Slots ready for issue |
| issue_valid_o | output | 1 | An issue candidate exists |
| issue_tag_o | output | TAG_W | Oldest ready slot |
| issue_op_o | output | OP_W | Payload of that slot |
| issue_opnd0_o | output | DATA_W | First operand of that slot |
| issue_opnd1_o | output | DATA_W | Second operand of that slot |
| issue_ack_i | input | 1 | Candidate accepted by an execution unit |
| rf_we_o | output | 1 | Retirement write enable |
| rf_waddr_o | output | REG_W | Retirement destination register |
| rf_wdata_o | output | DATA_W | Retirement value |

## Verification
The bench confines sources and destinations to four registers, so chains of producers that write the same register are common. A lookup that picks the oldest producer instead of the youngest would hand a consumer stale data, and the issued operand values would show it. Writebacks are often aimed at the producer of the operand being inserted in that cycle. A design without the same-cycle bypass would leave that operand pending forever, and its slot would never reach the issue list. The window is driven to full while inserts keep arriving, and it is flushed while slots are in every state. A pointer that wraps wrongly, or an insert accepted while full, then appears as a wrong tag or occupancy. Retirements are compared against a model register file, which catches out-of-order retirement and any loss of the broadcast value.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_EXEC = 2'd2,
      SLOT_DONE = 2'd3
   } slot_state_e;

   localparam int unsigned NSRC = 2;

endpackage

// File: rtl/rob_src_lookup.sv
module rob_src_lookup #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned TAG_W = $clog2(DEPTH)
) (
   input  logic [REG_W-1:0]                 src_reg_i,
   input  logic [DATA_W-1:0]                rf_data_i,
   input  logic [TAG_W-1:0]                 head_i,
   input  logic [TAG_W:0]                   live_i,
   input  logic [DEPTH-1:0][REG_W-1:0]      dst_i,
   input  logic [DEPTH-1:0]                 done_i,
   input  logic [DEPTH-1:0][DATA_W-1:0]     res_i,
   input  logic                             wb_valid_i,
   input  logic [TAG_W-1:0]                 wb_tag_i,
   input  logic [DATA_W-1:0]                wb_data_i,
   output logic                             opnd_valid_o,
   output logic [DATA_W-1:0]                opnd_data_o,
   output logic [TAG_W-1:0]                 opnd_tag_o
);

   logic             hit;
   logic [TAG_W-1:0] hit_idx;

   // scan from oldest to youngest; the last match is the youngest producer
   always_comb begin
      logic [TAG_W-1:0] idx;
      hit     = 1'b0;
      hit_idx = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = head_i + TAG_W'(k);
         if ((TAG_W+1)'(k) < live_i && dst_i[idx] == src_reg_i) begin
            hit     = 1'b1;
            hit_idx = idx;
         end
      end
   end

   always_comb begin
      opnd_valid_o = 1'b1;
      opnd_data_o  = rf_data_i;
      opnd_tag_o   = hit_idx;
      if (hit) begin
         if (done_i[hit_idx]) begin
            opnd_data_o = res_i[hit_idx];
         end else if (wb_valid_i && wb_tag_i == hit_idx) begin
            opnd_data_o = wb_data_i;
         end else begin
            opnd_valid_o = 1'b0;
            opnd_data_o  = '0;
         end
      end
   end

endmodule

// File: rtl/rob_oldest_pick.sv
module rob_oldest_pick #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned TAG_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] ready_i,
   input  logic [TAG_W-1:0] head_i,
   output logic             found_o,
   output logic [TAG_W-1:0] sel_o
);

   // walk from youngest age to oldest so the oldest ready slot wins
   always_comb begin
      logic [TAG_W-1:0] idx;
      found_o = 1'b0;
      sel_o   = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         idx = head_i + TAG_W'(k);
         if (ready_i[idx]) begin
            found_o = 1'b1;
            sel_o   = idx;
         end
      end
   end

endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned REG_W  = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned OP_W   = 8,
   localparam int unsigned TAG_W = $clog2(DEPTH),
   localparam int unsigned PTR_W = TAG_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               ins_valid_i,
   input  logic [OP_W-1:0]    ins_op_i,
   input  logic [REG_W-1:0]   ins_dst_i,
   input  logic [REG_W-1:0]   ins_src0_i,
   input  logic [REG_W-1:0]   ins_src1_i,
   input  logic [DATA_W-1:0]  rf_rdata0_i,
   input  logic [DATA_W-1:0]  rf_rdata1_i,
   output logic [TAG_W-1:0]   ins_tag_o,
   output logic               full_o,
   output logic               empty_o,
   input  logic               wb_valid_i,
   input  logic [TAG_W-1:0]   wb_tag_i,
   input  logic [DATA_W-1:0]  wb_data_i,
   output logic [DEPTH-1:0]   issue_ready_o,
   output logic               issue_valid_o,
   output logic [TAG_W-1:0]   issue_tag_o,
   output logic [OP_W-1:0]    issue_op_o,
   output logic [DATA_W-1:0]  issue_opnd0_o,
   output logic [DATA_W-1:0]  issue_opnd1_o,
   input  logic               issue_ack_i,
   output logic               rf_we_o,
   output logic [REG_W-1:0]   rf_waddr_o,
   output logic [DATA_W-1:0]  rf_wdata_o
);

   generate
      if (DEPTH < 2 || (1 << TAG_W) != DEPTH) begin : g_bad_depth
         $error("rob_core: DEPTH must be a power of two of at least 2");
      end
      if (REG_W < 1 || DATA_W < 1 || OP_W < 1) begin : g_bad_width
         $error("rob_core: widths must be positive");
      end
   endgenerate

   // ---------------- storage ----------------
   slot_state_e                         st_q [DEPTH];
   logic [PTR_W-1:0]                    head_q, tail_q;
   logic [DEPTH-1:0][OP_W-1:0]          op_q;
   logic [DEPTH-1:0][REG_W-1:0]         dst_q;
   logic [DEPTH-1:0][DATA_W-1:0]        res_q;
   logic [DEPTH-1:0][NSRC-1:0]          opv_q;
   logic [DEPTH-1:0][NSRC-1:0][TAG_W-1:0]  opt_q;
   logic [DEPTH-1:0][NSRC-1:0][DATA_W-1:0] opd_q;

   // ---------------- derived status ----------------
   logic [PTR_W-1:0] live;
   logic [TAG_W-1:0] head_idx, tail_idx;
   logic [DEPTH-1:0] done_vec, ready_vec;
   logic             ins_fire, commit_w, issue_fire;
   logic [TAG_W-1:0] issue_sel;
   logic             issue_found;

   assign live     = tail_q - head_q;
   assign head_idx = head_q[TAG_W-1:0];
   assign tail_idx = tail_q[TAG_W-1:0];
   assign full_o   = (live == PTR_W'(DEPTH));
   assign empty_o  = (live == '0);
   assign ins_tag_o = tail_idx;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot_flags
         assign done_vec[g]  = (st_q[g] == SLOT_DONE);
         assign ready_vec[g] = (st_q[g] == SLOT_WAIT) && (&opv_q[g]);
      end
   endgenerate

   assign ins_fire   = ins_valid_i && !full_o && !flush_i;
   assign commit_w   = done_vec[head_idx] && !empty_o && !flush_i;
   assign issue_fire = issue_found && issue_ack_i && !flush_i;

   // ---------------- operand capture ----------------
   logic [NSRC-1:0][REG_W-1:0]  src_reg;
   logic [NSRC-1:0][DATA_W-1:0] src_rf;
   logic [NSRC-1:0]             cap_v;
   logic [NSRC-1:0][DATA_W-1:0] cap_d;
   logic [NSRC-1:0][TAG_W-1:0]  cap_t;

   assign src_reg = {ins_src1_i, ins_src0_i};
   assign src_rf  = {rf_rdata1_i, rf_rdata0_i};

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         rob_src_lookup #(
            .DEPTH (DEPTH),
            .REG_W (REG_W),
            .DATA_W(DATA_W)
         ) u_lookup (
            .src_reg_i   (src_reg[s]),
            .rf_data_i   (src_rf[s]),
            .head_i      (head_idx),
            .live_i      (live),
            .dst_i       (dst_q),
            .done_i      (done_vec),
            .res_i       (res_q),
            .wb_valid_i  (wb_valid_i),
            .wb_tag_i    (wb_tag_i),
            .wb_data_i   (wb_data_i),
            .opnd_valid_o(cap_v[s]),
            .opnd_data_o (cap_d[s]),
            .opnd_tag_o  (cap_t[s])
         );
      end
   endgenerate

   // ---------------- issue select ----------------
   rob_oldest_pick #(.DEPTH(DEPTH)) u_pick (
      .ready_i(ready_vec),
      .head_i (head_idx),
      .found_o(issue_found),
      .sel_o  (issue_sel)
   );

   assign issue_ready_o = ready_vec;
   assign issue_valid_o = issue_found;
   assign issue_tag_o   = issue_sel;
   assign issue_op_o    = op_q[issue_sel];
   assign issue_opnd0_o = opd_q[issue_sel][0];
   assign issue_opnd1_o = opd_q[issue_sel][1];

   // ---------------- retirement ----------------
   assign rf_we_o    = commit_w;
   assign rf_waddr_o = dst_q[head_idx];
   assign rf_wdata_o = res_q[head_idx];

   // ---------------- control state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      end else if (flush_i) begin
         head_q <= '0;
         tail_q <= '0;
         for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wb_valid_i && wb_tag_i == TAG_W'(i) && st_q[i] != SLOT_FREE)
               st_q[i] <= SLOT_DONE;
            if (issue_fire && issue_sel == TAG_W'(i))
               st_q[i] <= SLOT_EXEC;
            if (commit_w && head_idx == TAG_W'(i))
               st_q[i] <= SLOT_FREE;
            if (ins_fire && tail_idx == TAG_W'(i))
               st_q[i] <= SLOT_WAIT;
         end
         head_q <= head_q + PTR_W'(commit_w);
         tail_q <= tail_q + PTR_W'(ins_fire);
      end
   end

   // ---------------- payload ----------------
   always_ff @(posedge clk) begin
      if (!flush_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j < NSRC; j++) begin
               if (wb_valid_i && st_q[i] != SLOT_FREE && !opv_q[i][j]
                   && opt_q[i][j] == wb_tag_i) begin
                  opv_q[i][j] <= 1'b1;
                  opd_q[i][j] <= wb_data_i;
               end
            end
            if (wb_valid_i && wb_tag_i == TAG_W'(i) && st_q[i] != SLOT_FREE)
               res_q[i] <= wb_data_i;
            if (ins_fire && tail_idx == TAG_W'(i)) begin
               op_q[i]  <= ins_op_i;
               dst_q[i] <= ins_dst_i;
               opv_q[i] <= cap_v;
               opt_q[i] <= cap_t;
               opd_q[i] <= cap_d;
            end
         end
      end
   end

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned TAG_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush_i,
   input logic             ins_valid_i,
   input logic             full_o,
   input logic             empty_o,
   input logic             rf_we_o,
   input logic [DEPTH-1:0] issue_ready_o,
   input logic             issue_valid_o,
   input logic [TAG_W-1:0] issue_tag_o,
   input logic             issue_ack_i
);

   // R3: occupancy flags are mutually exclusive
   assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

   // R3: an insert offered while full without a retirement leaves it full
   assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && ins_valid_i && !flush_i && !rf_we_o) |=> full_o);

   // R1: flush empties the window on the next edge
   assert_flush_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (empty_o && !full_o && issue_ready_o == '0));

   // R8: the presented candidate is one of the ready slots
   assert_pick_is_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> issue_ready_o[issue_tag_o]);

   // R8: an accepted slot never requests issue again next cycle
   assert_no_double_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid_o && issue_ack_i && !flush_i) |=> !issue_ready_o[$past(issue_tag_o)]);

   // R9: retirement only from an occupied window
   assert_commit_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> !empty_o);

endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .flush_i      (flush_i),
   .ins_valid_i  (ins_valid_i),
   .full_o       (full_o),
   .empty_o      (empty_o),
   .rf_we_o      (rf_we_o),
   .issue_ready_o(issue_ready_o),
   .issue_valid_o(issue_valid_o),
   .issue_tag_o  (issue_tag_o),
   .issue_ack_i  (issue_ack_i)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;

   localparam int PERIOD = 10;
   localparam int DEPTH  = 8;
   localparam int REG_W  = 5;
   localparam int DATA_W = 32;
   localparam int OP_W   = 8;
   localparam int TAG_W  = 3;
   localparam int NREG   = 32;
   localparam int CYCLES = 4000;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               flush_i = 1'b0;
   logic               ins_valid_i = 1'b0;
   logic [OP_W-1:0]    ins_op_i = '0;
   logic [REG_W-1:0]   ins_dst_i = '0;
   logic [REG_W-1:0]   ins_src0_i = '0;
   logic [REG_W-1:0]   ins_src1_i = '0;
   logic [DATA_W-1:0]  rf_rdata0_i, rf_rdata1_i;
   logic [TAG_W-1:0]   ins_tag_o;
   logic               full_o, empty_o;
   logic               wb_valid_i = 1'b0;
   logic [TAG_W-1:0]   wb_tag_i = '0;
   logic [DATA_W-1:0]  wb_data_i = '0;
   logic [DEPTH-1:0]   issue_ready_o;
   logic               issue_valid_o;
   logic [TAG_W-1:0]   issue_tag_o;
   logic [OP_W-1:0]    issue_op_o;
   logic [DATA_W-1:0]  issue_opnd0_o, issue_opnd1_o;
   logic               issue_ack_i = 1'b0;
   logic               rf_we_o;
   logic [REG_W-1:0]   rf_waddr_o;
   logic [DATA_W-1:0]  rf_wdata_o;

   // bench register file, read by the block at insert time
   logic [DATA_W-1:0] rf_m [NREG];
   assign rf_rdata0_i = rf_m[ins_src0_i];
   assign rf_rdata1_i = rf_m[ins_src1_i];

   always #(PERIOD/2) clk = ~clk;

   rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .ins_valid_i(ins_valid_i), .ins_op_i(ins_op_i), .ins_dst_i(ins_dst_i),
      .ins_src0_i(ins_src0_i), .ins_src1_i(ins_src1_i),
      .rf_rdata0_i(rf_rdata0_i), .rf_rdata1_i(rf_rdata1_i),
      .ins_tag_o(ins_tag_o), .full_o(full_o), .empty_o(empty_o),
      .wb_valid_i(wb_valid_i), .wb_tag_i(wb_tag_i), .wb_data_i(wb_data_i),
      .issue_ready_o(issue_ready_o), .issue_valid_o(issue_valid_o),
      .issue_tag_o(issue_tag_o), .issue_op_o(issue_op_o),
      .issue_opnd0_o(issue_opnd0_o), .issue_opnd1_o(issue_opnd1_o),
      .issue_ack_i(issue_ack_i),
      .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o)
   );

   // ---------------- behavioural reference ----------------
   // state: 0 free, 1 waiting, 2 executing, 3 done
   int          m_st [DEPTH];
   int          m_op [DEPTH];
   int          m_dst[DEPTH];
   bit          m_v  [DEPTH][2];
   int          m_t  [DEPTH][2];
   logic [31:0] m_d  [DEPTH][2];
   logic [31:0] m_res[DEPTH];
   int          m_head, m_cnt;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", rq, what, act, exp, $time);
      end
   endtask

   function automatic int ready_mask();
      int m = 0;
      for (int i = 0; i < DEPTH; i++)
         if (m_st[i] == 1 && m_v[i][0] && m_v[i][1]) m = m | (1 << i);
      return m;
   endfunction

   function automatic int oldest_ready();
      int rm = ready_mask();
      for (int k = 0; k < m_cnt; k++)
         if (rm[(m_head + k) % DEPTH]) return (m_head + k) % DEPTH;
      return -1;
   endfunction

   task automatic check_outputs();
      int pk;
      bit cm;
      pk = oldest_ready();
      cm = (m_cnt > 0) && (m_st[m_head] == 3) && !flush_i;
      // R1 R3: occupancy
      chk(empty_o == (m_cnt == 0), "R1 R3", "empty", 32'(empty_o), 32'(m_cnt == 0));
      chk(full_o == (m_cnt == DEPTH), "R1 R3", "full", 32'(full_o), 32'(m_cnt == DEPTH));
      // R2: tail tag
      chk(int'(ins_tag_o) == (m_head + m_cnt) % DEPTH, "R2", "ins_tag",
          32'(ins_tag_o), 32'((m_head + m_cnt) % DEPTH));
      // R8 R6: ready set
      chk(int'(issue_ready_o) == ready_mask(), "R8 R6", "ready_mask",
          32'(issue_ready_o), 32'(ready_mask()));
      chk(issue_valid_o == (pk >= 0), "R8", "issue_valid", 32'(issue_valid_o), 32'(pk >= 0));
      if (pk >= 0) begin
         chk(int'(issue_tag_o) == pk, "R8", "issue_tag", 32'(issue_tag_o), 32'(pk));
         chk(int'(issue_op_o) == m_op[pk], "R8", "issue_op", 32'(issue_op_o), 32'(m_op[pk]));
         // R4 R5 R6 R7: operand values as captured or broadcast
         chk(issue_opnd0_o == m_d[pk][0], "R4 R5 R6 R7", "opnd0", issue_opnd0_o, m_d[pk][0]);
         chk(issue_opnd1_o == m_d[pk][1], "R4 R5 R6 R7", "opnd1", issue_opnd1_o, m_d[pk][1]);
      end
      // R9: in-order retirement
      chk(rf_we_o == cm, "R9", "rf_we", 32'(rf_we_o), 32'(cm));
      if (cm) begin
         chk(int'(rf_waddr_o) == m_dst[m_head], "R9", "rf_waddr",
             32'(rf_waddr_o), 32'(m_dst[m_head]));
         chk(rf_wdata_o == m_res[m_head], "R9", "rf_wdata", rf_wdata_o, m_res[m_head]);
      end
   endtask

   task automatic lookup(input int src, input logic [31:0] rfv,
                         output bit v, output logic [31:0] d, output int t);
      int hit = -1;
      for (int k = m_cnt - 1; k >= 0; k--) begin
         if (hit < 0 && m_dst[(m_head + k) % DEPTH] == src) hit = (m_head + k) % DEPTH;
      end
      v = 1'b1; d = rfv; t = 0;
      if (hit >= 0) begin
         t = hit;
         if (m_st[hit] == 3) d = m_res[hit];
         else if (wb_valid_i && int'(wb_tag_i) == hit) d = wb_data_i;
         else begin v = 1'b0; d = '0; end
      end
   endtask

   task automatic model_edge();
      int tail, pk;
      bit ins, cm, fire;
      bit v0, v1;
      logic [31:0] d0, d1;
      int t0, t1;
      if (flush_i) begin
         for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
         m_head = 0; m_cnt = 0;
         return;
      end
      tail = (m_head + m_cnt) % DEPTH;
      pk   = oldest_ready();
      ins  = ins_valid_i && (m_cnt < DEPTH);
      cm   = (m_cnt > 0) && (m_st[m_head] == 3);
      fire = (pk >= 0) && issue_ack_i;
      lookup(int'(ins_src0_i), rf_rdata0_i, v0, d0, t0);
      lookup(int'(ins_src1_i), rf_rdata1_i, v1, d1, t1);
      if (wb_valid_i) begin
         for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < 2; j++)
               if (m_st[i] != 0 && !m_v[i][j] && m_t[i][j] == int'(wb_tag_i)) begin
                  m_v[i][j] = 1'b1; m_d[i][j] = wb_data_i;
               end
         if (m_st[wb_tag_i] != 0) begin
            m_st[wb_tag_i] = 3; m_res[wb_tag_i] = wb_data_i;
         end
      end
      if (fire) m_st[pk] = 2;
      if (cm) begin
         rf_m[m_dst[m_head]] = m_res[m_head];
         m_st[m_head] = 0;
         m_head = (m_head + 1) % DEPTH;
         m_cnt--;
      end
      if (ins) begin
         m_st[tail] = 1; m_op[tail] = int'(ins_op_i); m_dst[tail] = int'(ins_dst_i);
         m_v[tail][0] = v0; m_d[tail][0] = d0; m_t[tail][0] = t0;
         m_v[tail][1] = v1; m_d[tail][1] = d1; m_t[tail][1] = t1;
         m_cnt++;
      end
   endtask

   task automatic pick_inputs(input int cyc);
      int ex [DEPTH];
      int nex = 0;
      flush_i = (cyc == 1500 || cyc == 2600 || cyc == 2601);
      if (cyc < 40) begin
         // fill phase: window fills, further inserts must be ignored
         ins_valid_i = 1'b1;
         ins_dst_i   = REG_W'(cyc % 4);
         ins_src0_i  = REG_W'((cyc + 1) % 4);
         ins_src1_i  = REG_W'((cyc + 2) % 4);
         ins_op_i    = OP_W'(cyc);
         issue_ack_i = 1'b0;
         wb_valid_i  = 1'b0;
         return;
      end
      ins_valid_i = ($urandom % 4) != 0;
      ins_dst_i   = REG_W'($urandom % 4);
      ins_src0_i  = REG_W'($urandom % 4);
      ins_src1_i  = REG_W'($urandom % 4);
      ins_op_i    = OP_W'($urandom);
      issue_ack_i = ($urandom % 3) != 0;
      for (int i = 0; i < DEPTH; i++) if (m_st[i] == 2) begin ex[nex] = i; nex++; end
      wb_valid_i = 1'b0;
      if (nex > 0 && ($urandom % 2) == 1) begin
         wb_valid_i = 1'b1;
         wb_tag_i   = TAG_W'(ex[$urandom % nex]);
         wb_data_i  = $urandom;
         // steer a source at the entry being written back (same-cycle bypass)
         if (($urandom % 2) == 1) ins_src0_i = REG_W'(m_dst[wb_tag_i]);
      end
   endtask

   initial begin
      for (int r = 0; r < NREG; r++) rf_m[r] = 32'h1000 + 32'(r) * 32'h11;
      for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
      m_head = 0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state held in reset
      check_outputs();
      rst_n = 1'b1;
      for (int cyc = 0; cyc < CYCLES; cyc++) begin
         pick_inputs(cyc);
         #1;
         check_outputs();
         @(posedge clk);
         #1;
         model_edge();
         @(negedge clk);
      end
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 200000);
      if (!done_flag) begin
         done_flag = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule